// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the program counter of the next instruction for an 8-bit controller whose instructions are one to three bytes long: an opcode byte followed by up to two operand bytes. Each cycle it takes the current PC, the length of the instruction now executing, a 3-bit branch kind, the opcode and operand bytes, the accumulator value and the carry flag. One clock later it presents the next PC, a flag that says whether control left the straight-line path, and the carry value that follows the instruction.

It handles plain fall-through and short relative jumps. It also handles absolute jumps inside a 2 KB page, and conditional relative jumps. Those can test whether the accumulator is zero, test the carry flag, or compare the accumulator with an immediate byte. Every relative offset is a signed byte. It is added to the address of the instruction that follows the branch, not to the address of the branch itself. Instruction fetch, calls, returns and 16-bit long jumps are handled elsewhere.

Top module: `brgen`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `npc_o` = 0, `taken_o` = 0 and `cy_o` = 0 after that edge.
- R2: All outputs are registered. They reflect the inputs sampled at the previous rising edge, and the fall-through address is `pc_i + len_i`. Kind 0 (sequential) always gives the fall-through address with `taken_o` = 0.
- R3: Kind 1 (short jump) always branches. `npc_o` = fall-through + sign-extended `op1_i`, and `taken_o` = 1.
- R4: PC arithmetic is 16 bits wide and wraps modulo 65536, both forward past 0xFFFF and backward below 0x0000.
- R5: Kind 2 (in-page jump) always branches to {fall-through[15:11], `op0_i`[7:5], `op1_i`}. The upper five bits come from the incremented PC, so a jump in the last bytes of a page reaches the next page.
- R6: Kind 3 branches by `op1_i` when `acc_i` is zero. Kind 4 branches by `op1_i` when `acc_i` is non-zero.
- R7: Kind 5 branches by `op1_i` when `carry_i` is 1. Kind 6 branches by `op1_i` when `carry_i` is 0.
- R8: Kind 7 (compare) branches by offset `op2_i` when `acc_i` differs from the immediate `op1_i`.
- R9: When a conditional kind's test fails, `npc_o` is the fall-through address and `taken_o` = 0.
- R10: For kind 7, `cy_o` = 1 exactly when `acc_i` < `op1_i`, treating both as unsigned. For every other kind, `cy_o` repeats `carry_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 16 | Address of the current instruction |
| len_i | input | 2 | Instruction length in bytes (1 to 3) |
| kind_i | input | 3 | Branch kind, encoded 0 to 7 as in R2 to R8 |
| op0_i | input | 8 | Opcode byte; bits 7:5 carry the upper three in-page target bits |
| op1_i | input | 8 | First operand byte: offset, low target byte or compare immediate |
| op2_i | input | 8 | Second operand byte: compare-branch offset |
| acc_i | input | 8 | Accumulator value |
| carry_i | input | 1 | Carry flag |
| npc_o | output | 16 | Next program counter |
| taken_o | output | 1 | High when the next PC is not the fall-through address |
| cy_o | output | 1 | Carry flag after the instruction |

## Verification
The bench aims at the offset base. A design that added the offset to the branch's own address would land two or three bytes short on every relative case. It also drives offsets across 0xFFFF and below 0x0000, where a design that did not sign-extend, or that carried into a seventeenth bit, would give a wrong address. An in-page jump from the top of a 2 KB page checks that the page bits come from the incremented PC; a design that used the old PC would stay in the old page. The compare tests use 0x80 against 0x7F, where a signed comparison would set carry wrongly, and an equal pair, which must fall through with carry clear.

// File: rtl/brgen_pkg.sv
package brgen_pkg;
  typedef enum logic [2:0] {
    BK_SEQ  = 3'd0,
    BK_SHRT = 3'd1,
    BK_PAGE = 3'd2,
    BK_AZ   = 3'd3,
    BK_ANZ  = 3'd4,
    BK_CS   = 3'd5,
    BK_CC   = 3'd6,
    BK_CMP  = 3'd7
  } br_kind_e;
endpackage

// File: rtl/brgen_seq_add.sv
module brgen_seq_add #(
  parameter int PC_W  = 16,
  parameter int LEN_W = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [LEN_W-1:0] len,
  output logic [PC_W-1:0]  fall
);
  assign fall = pc + {{(PC_W-LEN_W){1'b0}}, len};
endmodule

// File: rtl/brgen_target.sv
module brgen_target #(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int BYTE_W = 8
) (
  input  logic [PC_W-1:0]   fall,
  input  logic              use_op2,
  input  logic [BYTE_W-1:0] op0,
  input  logic [BYTE_W-1:0] op1,
  input  logic [BYTE_W-1:0] op2,
  output logic [PC_W-1:0]   rel_tgt,
  output logic [PC_W-1:0]   abs_tgt
);
  localparam int HI_W = PAGE_W - BYTE_W;

  logic [BYTE_W-1:0] off;
  logic [PC_W-1:0]   off_x;

  assign off     = use_op2 ? op2 : op1;
  assign off_x   = {{(PC_W-BYTE_W){off[BYTE_W-1]}}, off};
  assign rel_tgt = fall + off_x;
  assign abs_tgt = {fall[PC_W-1:PAGE_W], op0[BYTE_W-1 -: HI_W], op1};
endmodule

// File: rtl/brgen_cond.sv
module brgen_cond
  import brgen_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  br_kind_e          kind,
  input  logic [BYTE_W-1:0] acc,
  input  logic [BYTE_W-1:0] imm,
  input  logic              carry,
  output logic              take,
  output logic              pick_abs,
  output logic              use_op2,
  output logic              cy_next
);
  logic acc_zero;
  assign acc_zero = (acc == '0);

  always_comb begin
    take     = 1'b0;
    pick_abs = 1'b0;
    use_op2  = 1'b0;
    cy_next  = carry;
    unique case (kind)
      BK_SEQ:  take = 1'b0;
      BK_SHRT: take = 1'b1;
      BK_PAGE: begin take = 1'b1; pick_abs = 1'b1; end
      BK_AZ:   take = acc_zero;
      BK_ANZ:  take = !acc_zero;
      BK_CS:   take = carry;
      BK_CC:   take = !carry;
      BK_CMP: begin
        take    = (acc != imm);
        use_op2 = 1'b1;
        cy_next = (acc < imm);
      end
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/brgen.sv
module brgen
  import brgen_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int LEN_W  = 2,
  parameter int PAGE_W = 11,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        kind_i,
  input  logic [BYTE_W-1:0] op0_i,
  input  logic [BYTE_W-1:0] op1_i,
  input  logic [BYTE_W-1:0] op2_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic              carry_i,
  output logic [PC_W-1:0]   npc_o,
  output logic              taken_o,
  output logic              cy_o
);
  br_kind_e        kind;
  logic [PC_W-1:0] fall, rel_tgt, abs_tgt, nxt;
  logic            take, pick_abs, use_op2, cy_next;

  assign kind = br_kind_e'(kind_i);

  brgen_seq_add #(.PC_W(PC_W), .LEN_W(LEN_W)) u_seq (
    .pc(pc_i), .len(len_i), .fall(fall)
  );

  brgen_cond #(.BYTE_W(BYTE_W)) u_cond (
    .kind(kind), .acc(acc_i), .imm(op1_i), .carry(carry_i),
    .take(take), .pick_abs(pick_abs), .use_op2(use_op2), .cy_next(cy_next)
  );

  brgen_target #(.PC_W(PC_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_tgt (
    .fall(fall), .use_op2(use_op2), .op0(op0_i), .op1(op1_i), .op2(op2_i),
    .rel_tgt(rel_tgt), .abs_tgt(abs_tgt)
  );

  always_comb begin
    if (!take)         nxt = fall;
    else if (pick_abs) nxt = abs_tgt;
    else               nxt = rel_tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_o   <= '0;
      taken_o <= 1'b0;
      cy_o    <= 1'b0;
    end else begin
      npc_o   <= nxt;
      taken_o <= take;
      cy_o    <= cy_next;
    end
  end
endmodule

// File: rtl/brgen_chk.sv
module brgen_chk #(
  parameter int PC_W   = 16,
  parameter int LEN_W  = 2,
  parameter int PAGE_W = 11,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   pc_i,
  input logic [LEN_W-1:0]  len_i,
  input logic [2:0]        kind_i,
  input logic [BYTE_W-1:0] op1_i,
  input logic [BYTE_W-1:0] acc_i,
  input logic              carry_i,
  input logic [PC_W-1:0]   npc_o,
  input logic              taken_o,
  input logic              cy_o
);
  logic [PC_W-1:0] seq_pc;
  assign seq_pc = pc_i + PC_W'(len_i);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (npc_o == '0 && !taken_o && !cy_o));

  // R2
  seq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 3'd0) |=> (!taken_o && npc_o == $past(seq_pc)));

  // R3
  short_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 3'd1) |=> taken_o);

  // R5
  page_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 3'd2) |=> (taken_o && npc_o[PC_W-1:PAGE_W] == $past(seq_pc[PC_W-1:PAGE_W])));

  // R9
  not_taken_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    !taken_o |-> (npc_o == $past(seq_pc)));

  // R8
  cmp_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 3'd7 && acc_i == op1_i) |=> (!taken_o && !cy_o));

  // R10
  carry_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i != 3'd7) |=> (cy_o == $past(carry_i)));
endmodule

bind brgen brgen_chk #(.PC_W(PC_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .pc_i(pc_i), .len_i(len_i), .kind_i(kind_i),
  .op1_i(op1_i), .acc_i(acc_i), .carry_i(carry_i),
  .npc_o(npc_o), .taken_o(taken_o), .cy_o(cy_o)
);

// File: tb/brgen_test.sv
module brgen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pc_i = '0;
  logic [1:0]  len_i = 2'd1;
  logic [2:0]  kind_i = '0;
  logic [7:0]  op0_i = '0, op1_i = '0, op2_i = '0, acc_i = '0;
  logic        carry_i = 1'b0;
  logic [15:0] npc_o;
  logic        taken_o, cy_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  brgen uut (
    .clk(clk), .rst(rst), .pc_i(pc_i), .len_i(len_i), .kind_i(kind_i),
    .op0_i(op0_i), .op1_i(op1_i), .op2_i(op2_i), .acc_i(acc_i), .carry_i(carry_i),
    .npc_o(npc_o), .taken_o(taken_o), .cy_o(cy_o)
  );

  task automatic check(input string req, input logic [15:0] e_pc,
                       input logic e_tk, input logic e_cy);
    n_chk++;
    if (npc_o !== e_pc || taken_o !== e_tk || cy_o !== e_cy) begin
      n_bad++;
      $display("FAIL %s: got npc=%h taken=%b cy=%b, expected npc=%h taken=%b cy=%b",
               req, npc_o, taken_o, cy_o, e_pc, e_tk, e_cy);
    end
  endtask

  // drive on falling edge, captured at next rise, sampled at the following fall
  task automatic apply(input logic [2:0] k, input logic [15:0] pc, input logic [1:0] len,
                       input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] acc, input logic cy);
    kind_i = k; pc_i = pc; len_i = len; op0_i = b0; op1_i = b1; op2_i = b2;
    acc_i = acc; carry_i = cy;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", 16'h0000, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_seq;
    apply(3'd0, 16'h1000, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    check("R2", 16'h1001, 1'b0, 1'b0);
    apply(3'd0, 16'h1000, 2'd3, 8'hFF, 8'h80, 8'h80, 8'h00, 1'b1);
    check("R2/R10", 16'h1003, 1'b0, 1'b1);
  endtask

  task automatic t_short;
    apply(3'd1, 16'h0100, 2'd2, 8'h80, 8'h10, 8'h00, 8'h00, 1'b0);
    check("R3", 16'h0112, 1'b1, 1'b0);
    apply(3'd1, 16'h0100, 2'd2, 8'h80, 8'hFE, 8'h00, 8'h00, 1'b0);
    check("R3", 16'h0100, 1'b1, 1'b0);
  endtask

  task automatic t_wrap;
    apply(3'd1, 16'hFFFE, 2'd2, 8'h80, 8'h05, 8'h00, 8'h00, 1'b0);
    check("R4", 16'h0005, 1'b1, 1'b0);
    apply(3'd1, 16'h0000, 2'd2, 8'h80, 8'h80, 8'h00, 8'h00, 1'b0);
    check("R4", 16'hFF82, 1'b1, 1'b0);
  endtask

  task automatic t_page;
    apply(3'd2, 16'h1234, 2'd2, 8'hE1, 8'h56, 8'h00, 8'h00, 1'b0);
    check("R5", 16'h1756, 1'b1, 1'b0);
    apply(3'd2, 16'h07FE, 2'd2, 8'h21, 8'h10, 8'h00, 8'h00, 1'b0);
    check("R5", 16'h0910, 1'b1, 1'b0);
  endtask

  task automatic t_acc;
    apply(3'd3, 16'h2000, 2'd2, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0);
    check("R6", 16'h2022, 1'b1, 1'b0);
    apply(3'd3, 16'h2000, 2'd2, 8'h00, 8'h20, 8'h00, 8'h05, 1'b0);
    check("R6/R9", 16'h2002, 1'b0, 1'b0);
    apply(3'd4, 16'h2000, 2'd2, 8'h00, 8'h20, 8'h00, 8'h05, 1'b0);
    check("R6", 16'h2022, 1'b1, 1'b0);
    apply(3'd4, 16'h2000, 2'd2, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0);
    check("R6/R9", 16'h2002, 1'b0, 1'b0);
  endtask

  task automatic t_carry;
    apply(3'd5, 16'h4000, 2'd2, 8'h00, 8'hF0, 8'h00, 8'h00, 1'b1);
    check("R7", 16'h3FF2, 1'b1, 1'b1);
    apply(3'd5, 16'h4000, 2'd2, 8'h00, 8'hF0, 8'h00, 8'h00, 1'b0);
    check("R7/R9", 16'h4002, 1'b0, 1'b0);
    apply(3'd6, 16'h4000, 2'd2, 8'h00, 8'hF0, 8'h00, 8'h00, 1'b0);
    check("R7", 16'h3FF2, 1'b1, 1'b0);
    apply(3'd6, 16'h4000, 2'd2, 8'h00, 8'hF0, 8'h00, 8'h00, 1'b1);
    check("R7/R9", 16'h4002, 1'b0, 1'b1);
  endtask

  task automatic t_cmp;
    apply(3'd7, 16'h3000, 2'd3, 8'h00, 8'h20, 8'hF0, 8'h10, 1'b0);
    check("R8/R10", 16'h2FF3, 1'b1, 1'b1);
    apply(3'd7, 16'h3000, 2'd3, 8'h00, 8'h20, 8'h08, 8'h30, 1'b1);
    check("R8/R10", 16'h300B, 1'b1, 1'b0);
    apply(3'd7, 16'h3000, 2'd3, 8'h00, 8'h20, 8'h08, 8'h20, 1'b1);
    check("R8/R9", 16'h3003, 1'b0, 1'b0);
    apply(3'd7, 16'h3000, 2'd3, 8'h00, 8'h7F, 8'h04, 8'h80, 1'b0);
    check("R10", 16'h3007, 1'b1, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_seq();
    t_short();
    t_wrap();
    t_page();
    t_acc();
    t_carry();
    t_cmp();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule